// File: doc/BRIEF.md
# Transmit Stream Arbiter with Priority Completions

This block decides which of four packet sources may drive the one 64-bit transmit stream that feeds the PCIe core. The sources are fixed slots. Slot 0 carries completions that answer host register reads. Slot 1 carries memory read requests. Slot 2 carries memory write packets bound for host memory. Slot 3 carries posted writes aimed at peer endpoints. Every source presents beats with valid, data and a last-beat flag. The arbiter joins the granted source straight to the output stream, with no storage in the data path.

Completions beat every other source, but only at a packet boundary. The three request slots take turns in a fixed ring, one whole packet per turn. A source that wins the stream keeps it until its last beat has been accepted. Choosing the next owner adds no latency: the first beat of a packet can leave in the same cycle its source is chosen. The receive side is separate and does not interact with this block.

Top module: `txarb_top`

## Requirements
- R1: While reset is held, and after it while no source is valid, `out_valid` is 0 and every bit of `src_ready` is 0. After reset the ring starts at slot 1, so slot 1 is the first request slot served when slots 1, 2 and 3 all wait.
- R2: At a packet boundary, a valid slot 0 (completion) is granted ahead of any valid request slot.
- R3: The request slots 1, 2 and 3 are served in the ring order 1, 2, 3, 1. After a packet from slot k ends, the search starts at the slot after k, and idle slots are skipped.
- R4: Once a beat without last is accepted from a slot, only that slot's beats appear on the output until its last beat is accepted.
- R5: `out_valid`, `out_data` and `out_last` are the granted slot's signals. Only the granted slot's `src_ready` may be 1, and it equals `out_ready`. All other `src_ready` bits are 0.
- R6: While `out_ready` is 0 in the middle of a packet, the grant does not change, so the output beat stays the same until it is accepted.
- R7: A completion that becomes valid in the middle of another packet does not interrupt it. It is the first packet sent after that packet's last beat.
- R8: A served completion leaves the ring position unchanged.
- R9: A packet of one beat (last set on its first beat) does not lock the stream. A new choice is made in the next cycle.
- R10: With sources waiting and `out_ready` held at 1, consecutive packets follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 4 | Beat valid per slot (0 completion, 1 memory read, 2 memory write, 3 peer write) |
| src_data | input | 256 | Beat data per slot, slot i in bits i*64 +: 64 |
| src_last | input | 4 | Last beat of packet per slot |
| src_ready | output | 4 | Beat accepted per slot |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 64 | Output beat data |
| out_last | output | 1 | Output last beat |
| out_ready | input | 1 | Downstream accepts the beat |

## Verification
The bench targets a completion that arrives while a four-beat request packet is in flight. A design that pre-empts at beat level would splice completion beats into that packet, and a scoreboard order mismatch would expose it. A second target is ring state after completions are served. A design that advances the pointer on a completion would serve the wrong request slot next.

Backpressure in the middle of a packet is applied with a repeating `out_ready` pattern. A lock that releases during a stall would let the output beat change before it is accepted. Single-beat packets and a dense back-to-back burst are also timed. A design that leaves a lock stuck after a one-beat packet would hang. A design that adds a cycle per arbitration decision would show idle cycles between packets.

// File: rtl/txarb_pkg.sv
// Package: shared constants for the transmit stream arbiter.
// Assumes slot 0 is the completion slot and slots 1.. are request slots.
package txarb_pkg;
    // Slot index of the completion source, which has absolute priority.
    localparam int CPL_SLOT = 0;
    // Fixed slot indices of the three request sources.
    typedef enum logic [1:0] {
        SLOT_CPL  = 2'd0,
        SLOT_MRD  = 2'd1,
        SLOT_MWR  = 2'd2,
        SLOT_PEER = 2'd3
    } slot_e;
endpackage

// File: rtl/txarb_rr_pick.sv
// Module: txarb_rr_pick
// Round-robin selector over N request lines. It picks the first active
// request at or after the ring pointer. When the caller reports a finished
// packet (adv with a one-hot adv_oh), the pointer moves to the slot after
// the served one.
// Assumes adv_oh is one-hot whenever adv is 1.
module txarb_rr_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    input  logic [N-1:0] adv_oh,
    output logic [N-1:0] gnt_oh
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;

    // Scan the ring from the pointer and pick the first active request.
    always_comb begin
        logic found;
        gnt_oh = '0;
        found  = 1'b0;
        for (int off = 0; off < N; off++) begin
            int k;
            k = int'(ptr) + off;
            if (k >= N) k = k - N;
            if (!found && req[k]) begin
                gnt_oh[k] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // Move the pointer past the slot that just finished a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            for (int i = 0; i < N; i++) begin
                if (adv_oh[i]) ptr <= (i == N - 1) ? '0 : PW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/txarb_lock.sv
// Module: txarb_lock
// Holds the grant from the first accepted beat of a packet to its last
// accepted beat. When no packet is open, the grant follows the pick made
// this cycle, so a new first beat can leave with no bubble.
// Assumes pick_oh is one-hot or zero.
module txarb_lock #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] pick_oh,
    input  logic          beat,
    input  logic          beat_last,
    output logic [NS-1:0] grant_oh,
    output logic          locked
);
    logic [NS-1:0] owner_oh;

    // Use the held owner inside a packet and the fresh pick at a boundary.
    always_comb grant_oh = locked ? owner_oh : pick_oh;

    // Open the lock on a beat without last; close it on a beat with last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            owner_oh <= '0;
        end else if (beat) begin
            if (beat_last) begin
                locked <= 1'b0;
            end else begin
                locked   <= 1'b1;
                owner_oh <= grant_oh;
            end
        end
    end
endmodule

// File: rtl/txarb_top.sv
// Module: txarb_top
// Transmit stream arbiter. Slot 0 (completions) wins at every packet
// boundary. The request slots share the stream in round-robin order, one
// packet per turn. Valid, data and last pass straight through from the
// granted slot, and only that slot sees ready.
// Assumes each source holds valid, data and last stable until they are
// accepted.
module txarb_top
    import txarb_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int NUM_REQ = 3,
    localparam int NUM_SRC = NUM_REQ + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    input  logic [NUM_SRC-1:0]        src_last,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_last,
    input  logic                      out_ready
);
    logic [NUM_REQ-1:0] rr_gnt;
    logic [NUM_SRC-1:0] pick_oh;
    logic [NUM_SRC-1:0] grant_oh;
    logic               locked;
    logic               beat;
    logic               rr_adv;

    // Completion first; otherwise the round-robin choice among requests.
    always_comb begin
        pick_oh = '0;
        if (src_valid[CPL_SLOT]) pick_oh[CPL_SLOT] = 1'b1;
        else                     pick_oh[NUM_SRC-1:1] = rr_gnt;
    end

    // Move the ring only when a request packet ends, never on a completion.
    assign beat   = out_valid && out_ready;
    assign rr_adv = beat && out_last && !grant_oh[CPL_SLOT];

    txarb_rr_pick #(.N(NUM_REQ)) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (src_valid[NUM_SRC-1:1]),
        .adv    (rr_adv),
        .adv_oh (grant_oh[NUM_SRC-1:1]),
        .gnt_oh (rr_gnt)
    );

    txarb_lock #(.NS(NUM_SRC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_oh   (pick_oh),
        .beat      (beat),
        .beat_last (out_last),
        .grant_oh  (grant_oh),
        .locked    (locked)
    );

    // Pass the granted slot's beat to the output and ready back to it.
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_oh[i]) begin
                out_valid = out_valid | src_valid[i];
                out_data  = out_data | src_data[i*DATA_W +: DATA_W];
                out_last  = out_last | src_last[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_ready
            assign src_ready[g] = grant_oh[g] && out_ready;
        end
    endgenerate

    // R5: at most one slot sees ready.
    p_one_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));

    // R1: no valid source means no output beat and no ready.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid == '0) |-> (!out_valid && src_ready == '0));

    // R2: at a boundary a waiting completion is the slot that gets ready.
    p_cpl_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && src_valid[CPL_SLOT] && out_ready) |-> src_ready[CPL_SLOT]);

    // R4: a beat without last keeps the same owner in the next cycle.
    p_keep_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !out_last) |=> (grant_oh == $past(grant_oh)));

    // R6: a stall inside a packet does not change the grant.
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !out_ready) |=> (grant_oh == $past(grant_oh)));

    // R9: a single-beat packet leaves the stream unlocked.
    p_single_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && out_last) |=> !locked);
endmodule

// File: tb/sim_txarb_top.sv
// Scoreboard bench: loader tasks queue packets per slot and push the
// expected output order. A monitor pops and compares each accepted beat.
module sim_txarb_top;
    import txarb_pkg::*;

    localparam int W  = 64;
    localparam int NS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src_valid = '0;
    logic [NS*W-1:0] src_data = '0;
    logic [NS-1:0]   src_last = '0;
    logic [NS-1:0]   src_ready;
    logic            out_valid;
    logic [W-1:0]    out_data;
    logic            out_last;
    logic            out_ready = 1'b1;

    always #5 clk = ~clk;

    txarb_top #(.DATA_W(W), .NUM_REQ(NS-1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    logic [W:0] srcq [NS][$];
    logic [W:0] expq [$];
    string      tagq [$];
    int errs = 0, checks = 0;
    int cyc = 0, nbeats = 0, first_cyc = -1, last_cyc = -1;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    function automatic logic [W-1:0] mk(int s, int p, int b);
        return {8'(s), 16'(p), 8'(b), 32'(32'h5A5A0000 + p * 7 + b)};
    endfunction

    function void refresh();
        for (int s = 0; s < NS; s++) begin
            if (srcq[s].size() > 0) begin
                src_valid[s]         = 1'b1;
                src_last[s]          = srcq[s][0][W];
                src_data[s*W +: W]   = srcq[s][0][W-1:0];
            end else begin
                src_valid[s]         = 1'b0;
                src_last[s]          = 1'b0;
                src_data[s*W +: W]   = '0;
            end
        end
    endfunction

    task automatic chk(bit ok, string req, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(int s, int p, int len);
        for (int b = 0; b < len; b++) srcq[s].push_back({(b == len - 1), mk(s, p, b)});
    endtask

    task automatic want(int s, int p, int len, string tag);
        for (int b = 0; b < len; b++) begin
            expq.push_back({(b == len - 1), mk(s, p, b)});
            tagq.push_back(tag);
        end
    endtask

    task automatic drain();
        while (expq.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Cycle counter.
    always @(posedge clk) cyc <= cyc + 1;

    // Source driver: pops accepted beats after each edge and drives out_ready.
    initial begin
        logic [NS-1:0] fire;
        forever begin
            @(negedge clk);
            fire = src_valid & src_ready;
            @(posedge clk);
            #1;
            for (int s = 0; s < NS; s++) if (fire[s]) void'(srcq[s].pop_front());
            out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
            refresh();
        end
    end

    // Monitor: compares accepted beats with the scoreboard and checks stalls.
    initial begin
        logic [W-1:0] held;
        bit           stalled;
        stalled = 1'b0;
        held    = '0;
        forever begin
            @(negedge clk);
            if (rst_n && stall_mode && stalled && out_valid)
                chk(out_data == held, "R6", {1'b0, out_data}, {1'b0, held});
            stalled = 1'b0;
            if (rst_n && out_valid && !out_ready) begin
                stalled = 1'b1;
                held    = out_data;
            end
            if (rst_n && out_valid && out_ready) begin
                int tag_slot;
                nbeats++;
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                tag_slot = int'(out_data[63:56]);
                chk(tag_slot < NS && src_ready == NS'(1 << tag_slot), "R5",
                    {1'b0, 60'd0, src_ready}, {1'b0, 60'd0, 4'(1 << tag_slot)});
                if (expq.size() == 0) begin
                    chk(1'b0, "R4", {out_last, out_data}, '0);
                end else begin
                    logic [W:0] e;
                    string      t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk({out_last, out_data} == e, t, {out_last, out_data}, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state with nothing queued.
        repeat (3) @(negedge clk);
        chk(!out_valid && src_ready == '0, "R1", {out_valid, 60'd0, src_ready}, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!out_valid && src_ready == '0, "R1", {out_valid, 60'd0, src_ready}, '0);

        // R3 / R10: all request slots busy, ring starts at slot 1 (R1).
        @(posedge clk); #1;
        nbeats = 0; first_cyc = -1;
        for (int p = 1; p <= 2; p++)
            for (int s = 1; s <= 3; s++) load(s, p, 2);
        want(1, 1, 2, "R1"); want(2, 1, 2, "R3"); want(3, 1, 2, "R3");
        want(1, 2, 2, "R3"); want(2, 2, 2, "R3"); want(3, 2, 2, "R3");
        refresh();
        drain();
        chk(last_cyc - first_cyc == 11, "R10", 65'(last_cyc - first_cyc), 65'd11);

        // Move ring to slot 2 by sending one packet from slot 1.
        load(1, 9, 1); want(1, 9, 1, "R3"); refresh();
        drain();

        // R2 / R8: completion first, ring still at slot 2 afterwards.
        load(0, 1, 3); load(1, 3, 2); load(2, 3, 2); load(3, 3, 1);
        want(0, 1, 3, "R2"); want(2, 3, 2, "R8"); want(3, 3, 1, "R3");
        want(1, 3, 2, "R3");
        refresh();
        drain();

        // R7 / R4 / R9: completion arrives inside a four-beat packet.
        nbeats = 0;
        load(3, 4, 4); want(3, 4, 4, "R4"); refresh();
        while (nbeats < 2) @(posedge clk);
        #1;
        load(0, 2, 1); load(1, 4, 1); load(2, 4, 2);
        want(0, 2, 1, "R7"); want(1, 4, 1, "R9"); want(2, 4, 2, "R9");
        refresh();
        drain();

        // R6: backpressure in the middle of packets, ring at slot 3.
        stall_mode = 1'b1;
        load(1, 5, 3); load(2, 5, 2); load(3, 5, 3);
        want(3, 5, 3, "R6"); want(1, 5, 3, "R6"); want(2, 5, 2, "R6");
        refresh();
        drain();
        stall_mode = 1'b0;

        // R1: quiet again once everything is sent.
        repeat (2) @(negedge clk);
        chk(!out_valid && src_ready == '0, "R1", {out_valid, 60'd0, src_ready}, '0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule